// File: doc/BRIEF.md
# Sense-Reversing Hardware Barrier

This block holds back a fixed group of requesters until all of them have reached a common synchronization point, then lets them all go in the same cycle. Each requester raises a one-cycle `arrive_i` pulse when it reaches the barrier. It then sees `release_o` low until the last member of the group has been counted. After that its `release_o` stays high until it pulses `arrive_i` again for the next episode.

Each requester has a private one-bit sense that inverts on every entry. A shared arrival counter is advanced by one requester at a time. A round-robin arbiter picks that requester. The arrival that completes the count zeroes the counter and copies its own sense into a global flag. Any requester whose sense equals the flag is released. The flag is never cleared, so a fast requester can re-enter at once without releasing anyone early and without deadlock.

Each requester runs a small state machine. Its states are:
- `ST_IDLE`: not yet entered, after reset.
- `ST_PEND`: entered and waiting for a counter grant.
- `ST_WAIT`: counted and waiting for the flag to match its sense.
- `ST_DONE`: released.

Its transitions are:
- enter (`ST_IDLE`/`ST_DONE` to `ST_PEND` on arrive, which inverts the sense).
- counted (`ST_PEND` to `ST_WAIT` on grant).
- freed (`ST_WAIT` to `ST_DONE` when the flag matches).
- re-enter (`ST_WAIT` with the flag matching, to `ST_PEND` on arrive).

Top module: `sense_barrier`

## Requirements
- R1: After reset the counter and flag are zero, every sense bit is zero and every `release_o` bit is low.
- R2: No `release_o` bit rises while any participant of the current episode has not yet arrived.
- R3: The counter advances by at most one arrival per cycle, and only for a pending requester. When N requesters arrive together, the last of them is counted on the N-th rising edge after the edge that samples the arrivals.
- R4: On the cycle after the edge that counts the N-th arrival, all N `release_o` bits are high together. Only that completing arrival changes the flag.
- R5: Arbitration is round-robin: a pending requester waits at most N-1 cycles for its grant.
- R6: A requester's `release_o` stays high until that requester's next arrive pulse. It is low from the cycle after that pulse is sampled.
- R7: An arrive pulse from a requester that is pending or waiting is ignored: it neither counts again nor changes any `release_o` bit.
- R8: Back-to-back episodes: requesters still released from the previous episode keep `release_o` high while others re-enter. The new episode releases everyone only after all N have arrived again.
- R9: The counter never exceeds N-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| arrive_i | input | N | One-cycle pulse per requester announcing entry to the barrier |
| release_o | output | N | Per-requester release level |

## Verification
Several properties are checked on every cycle:
- The arbiter grants at most one pending requester.
- Each pending requester's wait stays below N cycles.
- The counter stays in range.
- The flag moves only on a completing arrival.
- A release only rises right after such an arrival.
- A sampled arrive pulse drops the requester's release.

Other behaviour can only be shown by the bench's scenarios:
- The exact release cycle for N simultaneous arrivals.
- That arrivals in the pending or waiting states are not counted twice.
- That staggered groups, swept over every split of the participants, release together only when the last one arrives, across back-to-back episodes.

// File: rtl/sense_barrier_pkg.sv
package sense_barrier_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PEND = 2'd1,
        ST_WAIT = 2'd2,
        ST_DONE = 2'd3
    } part_state_t;
endpackage

// File: rtl/sb_rr_arbiter.sv
module sb_rr_arbiter #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    output logic [N-1:0] grant_o
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;
    localparam int WW = $clog2(N + 1);

    logic [IW-1:0] ptr_q, ptr_d;

    always_comb begin
        int  idx;
        logic found;
        grant_o = '0;
        ptr_d   = ptr_q;
        found   = 1'b0;
        for (int k = 0; k < N; k++) begin
            idx = int'(ptr_q) + k;
            if (idx >= N) idx = idx - N;
            if (!found && req_i[idx]) begin
                found        = 1'b1;
                grant_o[idx] = 1'b1;
                ptr_d        = (idx == N - 1) ? '0 : IW'(idx + 1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assert_grant_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));
    assert_grant_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & ~req_i) == '0);

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_wait
            logic [WW-1:0] wait_q;
            always_ff @(posedge clk) begin
                if (!rst_n)                          wait_q <= '0;
                else if (req_i[gi] && !grant_o[gi])  wait_q <= wait_q + 1'b1;
                else                                 wait_q <= '0;
            end
            assert_fair_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
                wait_q < WW'(N));
        end
    endgenerate
endmodule

// File: rtl/sb_arrival_counter.sv
module sb_arrival_counter #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] grant_i,
    input  logic [N-1:0] sense_i,
    output logic         flag_o,
    output logic         last_o
);
    localparam int CW = $clog2(N + 1);

    logic [CW-1:0] count_q;
    logic          sel_sense;
    logic          any_grant;

    assign any_grant = |grant_i;
    assign sel_sense = |(grant_i & sense_i);
    assign last_o    = any_grant && (count_q == CW'(N - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            flag_o  <= 1'b0;
        end else if (any_grant) begin
            if (last_o) begin
                count_q <= '0;
                flag_o  <= sel_sense;
            end else begin
                count_q <= count_q + 1'b1;
            end
        end
    end

    assert_count_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(N - 1));
    assert_flag_on_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(flag_o) |-> $past(last_o));
endmodule

// File: rtl/sb_participant.sv
module sb_participant
    import sense_barrier_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arrive_i,
    input  logic grant_i,
    input  logic flag_i,
    input  logic last_i,
    output logic sense_o,
    output logic req_o,
    output logic rel_o
);
    part_state_t state_q, state_d;
    logic        sense_d;
    logic        match;

    assign match = (flag_i == sense_o);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sense_o <= 1'b0;
        end else begin
            state_q <= state_d;
            sense_o <= sense_d;
        end
    end

    always_comb begin
        state_d = state_q;
        sense_d = sense_o;
        unique case (state_q)
            ST_IDLE, ST_DONE: if (arrive_i) begin
                state_d = ST_PEND;
                sense_d = ~sense_o;
            end
            ST_PEND: if (grant_i) state_d = ST_WAIT;
            ST_WAIT: if (match) begin
                if (arrive_i) begin
                    state_d = ST_PEND;
                    sense_d = ~sense_o;
                end else begin
                    state_d = ST_DONE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_o = (state_q == ST_PEND);
        rel_o = (state_q == ST_DONE) || ((state_q == ST_WAIT) && match);
    end

    assert_release_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (arrive_i && rel_o) |=> !rel_o);
    assert_release_after_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rel_o) |-> $past(last_i));
endmodule

// File: rtl/sense_barrier.sv
module sense_barrier #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] arrive_i,
    output logic [N-1:0] release_o
);
    logic [N-1:0] req, grant, sense;
    logic         flag, last;

    sb_rr_arbiter #(.N(N)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req),
        .grant_o (grant)
    );

    sb_arrival_counter #(.N(N)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .grant_i (grant),
        .sense_i (sense),
        .flag_o  (flag),
        .last_o  (last)
    );

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_part
            sb_participant u_part (
                .clk      (clk),
                .rst_n    (rst_n),
                .arrive_i (arrive_i[gi]),
                .grant_i  (grant[gi]),
                .flag_i   (flag),
                .last_i   (last),
                .sense_o  (sense[gi]),
                .req_o    (req[gi]),
                .rel_o    (release_o[gi])
            );
        end
    endgenerate
endmodule

// File: tb/sense_barrier_bench.sv
module sense_barrier_bench;
    localparam int N = 4;
    localparam logic [N-1:0] ALL = '1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] arrive = '0;
    logic [N-1:0] rel;
    logic [N-1:0] exp_rel;
    int           checks = 0;
    int           errors = 0;
    int           cyc = 0;
    bit           finished = 1'b0;

    always #2 clk = ~clk;

    sense_barrier #(.N(N)) u_sense_barrier (
        .clk       (clk),
        .rst_n     (rst_n),
        .arrive_i  (arrive),
        .release_o (rel)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input logic [N-1:0] exp, input string tag);
        checks++;
        if (rel !== exp) begin
            errors++;
            $display("FAIL %s release=%b expected=%b", tag, rel, exp);
        end
    endtask

    task automatic pulse(input logic [N-1:0] m);
        arrive = m;
        tick();
        arrive = '0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        exp_rel = '0;
        repeat (3) tick();
        check('0, "R1 in reset");
        rst_n = 1'b1;
        tick();
        check('0, "R1 after reset");

        // R3/R4: all arrive together, released on N-th edge after sampling
        pulse(ALL);
        check('0, "R3 simultaneous");
        for (int j = 1; j < N; j++) begin
            tick();
            check('0, "R3 serial count");
        end
        tick();
        exp_rel = ALL;
        check(exp_rel, "R4 joint release");

        // Sweep every split into an early group m and a late group
        for (int m = 1; m < (1 << N) - 1; m++) begin
            logic [N-1:0] g1, g2;
            int k;
            g1 = m[N-1:0];
            g2 = ~g1;
            k  = $countones(g2);
            pulse(g1);
            exp_rel &= ~g1;
            check(exp_rel, "R6 drop on arrive");
            for (int j = 0; j < N + 1; j++) begin
                tick();
                check(exp_rel, "R8 partial group held");
            end
            pulse(g1);
            check(exp_rel, "R7 repeat arrive ignored");
            tick();
            check(exp_rel, "R7 no double count");
            pulse(g2);
            exp_rel = '0;
            check(exp_rel, "R2 last group sampled");
            for (int j = 1; j < k; j++) begin
                tick();
                check(exp_rel, "R2 still counting");
            end
            tick();
            exp_rel = ALL;
            check(exp_rel, "R4 release together");
            tick();
            check(exp_rel, "R6 release holds");
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule